// File: doc/BRIEF.md
# Dual-Convention Multiplexed Host Bus Front End

This block is the host-facing front end of a small register-mapped peripheral. A host talks to it over one shared address/data bus. An address strobe marks the phase in which the bus carries the register address. A later strobe phase moves data in or out. A static mode pin picks one of two strobe conventions:

- In the first, a data strobe is paired with a read/write level.
- In the second, there are separate active-low read and write strobes.

All bus pins are oversampled by the block's own clock. The block turns them into a latched register address, a one-cycle write pulse with its data, a one-cycle read pulse, and an output-enable plus drive value for the shared bus.

A chip-enable input decides whether a data transfer takes place. The address phase is still recorded when chip enable is high. While the reset input is low, and for the two clock cycles it takes to release reset internally, no access can take place.

Top module: `mbi_front`

## Requirements
- R1: `mode_pin` equal to 1 selects the data-strobe convention. In this convention `ds_pin` high is the data strobe and `rw_pin` high means read. `mode_pin` at 0, or at any value that is not a definite 1 (undriven), selects the split-strobe convention. In that convention `ds_pin` is the read strobe (active low) and `rw_pin` is the write strobe (active low).
- R2: On each falling edge of `as_pin`, the low `ADDR_W` bits of `ad_in` are captured into `reg_addr`. `reg_addr` then holds that value until the next such edge, whatever the level of `ce_n`.
- R3: With `ce_n` high, no strobe activity produces `reg_wr`, produces `reg_rd`, or raises `ad_oe`.
- R4: In the data-strobe convention, a falling edge of `ds_pin` while `rw_pin` is low and `ce_n` is low gives exactly one `reg_wr` pulse. `reg_wdata` carries the `ad_in` value present at that edge. A falling edge of `ds_pin` with `rw_pin` high writes nothing.
- R5: In the split-strobe convention, a rising edge of `rw_pin` while `ce_n` is low gives exactly one `reg_wr` pulse. `reg_wdata` carries the `ad_in` value present at that edge.
- R6: `ad_oe` is high only while `ce_n` is low and a read strobe is active. In the data-strobe convention this means `ds_pin` high with `rw_pin` high. In the split-strobe convention this means `ds_pin` low. While `ad_oe` is high, `ad_out` equals `reg_rdata`. Otherwise `ad_oe` is low and `ad_out` is 0.
- R7: Each read strobe phase gives exactly one single-cycle `reg_rd` pulse, in the cycle where `ad_oe` rises.
- R8: While `rst_n` is low, and for 2 cycles after it rises, `reg_wr`, `reg_rd` and `ad_oe` stay low. During that time `reg_addr` is 0 and bus activity is ignored.
- R9: With `SYNC_STAGES`=2, a pin change made between clock edges shows on the outputs after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; refuses accesses while low |
| mode_pin | input | 1 | Convention select; 1 = data strobe with read/write level, otherwise split strobes |
| as_pin | input | 1 | Address strobe; address is captured on its falling edge |
| ds_pin | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_pin | input | 1 | Read/write level, high = read (mode 1), or active-low write strobe (mode 0) |
| ce_n | input | 1 | Active-low chip enable for data transfers |
| ad_in | input | DATA_W | Shared address/data bus, as seen at the pins |
| ad_out | output | DATA_W | Read data to drive onto the shared bus |
| ad_oe | output | 1 | Bus drive enable; bus is high-impedance when low |
| reg_addr | output | ADDR_W | Latched register address |
| reg_wdata | output | DATA_W | Write data for the register file |
| reg_wr | output | 1 | Single-cycle register write pulse |
| reg_rd | output | 1 | Single-cycle register read pulse |
| reg_rdata | input | DATA_W | Read data from the register file, addressed by `reg_addr` |

## Verification
The assertions assume that the host keeps `ad_in` stable from some time before a committing strobe edge until after it. They also assume that only one strobe changes between two clock edges, so every edge the block sees is paired with the right data and chip-enable level. The stimulus changes one pin at a time on falling clock edges and holds each level for several cycles. It also puts all pins into the idle levels of the new convention before `mode_pin` changes, so a switch in convention never looks like a strobe edge.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  typedef enum logic {
    CONV_SPLIT = 1'b0,
    CONV_DS_RW = 1'b1
  } conv_e;
endpackage

// File: rtl/mbi_sync.sv
// Pin oversampling pipeline; every bit passes through the same number of stages
module mbi_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) pipe_q[i] <= pipe_q[i-1];
      pipe_q[0] <= d;
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/mbi_strobe_decode.sv
// Turns sampled strobe levels into address, write and read events
module mbi_strobe_decode
  import mbi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  conv_e conv,
  input  logic  valid_s,
  input  logic  as_s,
  input  logic  ds_s,
  input  logic  rw_s,
  input  logic  ce_n_s,
  output logic  as_fall,
  output logic  wr_evt,
  output logic  rd_act,
  output logic  rd_start
);
  logic vld_p_q, as_p_q, ds_p_q, rw_p_q, rd_p_q;
  logic both_valid, ds_wr, split_wr;

  always_comb begin
    both_valid = valid_s & vld_p_q;
    as_fall    = both_valid & as_p_q & ~as_s;
    ds_wr      = ds_p_q & ~ds_s & ~rw_s;
    split_wr   = ~rw_p_q & rw_s;
    wr_evt     = both_valid & ~ce_n_s & ((conv == CONV_DS_RW) ? ds_wr : split_wr);
    rd_act     = valid_s & ~ce_n_s & ((conv == CONV_DS_RW) ? (ds_s & rw_s) : ~ds_s);
    rd_start   = rd_act & ~rd_p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_p_q <= 1'b0;
      as_p_q  <= 1'b0;
      ds_p_q  <= 1'b0;
      rw_p_q  <= 1'b0;
      rd_p_q  <= 1'b0;
    end else begin
      vld_p_q <= valid_s;
      as_p_q  <= as_s;
      ds_p_q  <= ds_s;
      rw_p_q  <= rw_s;
      rd_p_q  <= rd_act;
    end
  end
endmodule

// File: rtl/mbi_front.sv
module mbi_front
  import mbi_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin,
  input  logic              as_pin,
  input  logic              ds_pin,
  input  logic              rw_pin,
  input  logic              ce_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int SW = DATA_W + 5;

  // reset: asserted at once, released after RST_STAGES clocks
  logic [RST_STAGES-1:0] rst_q;
  logic                  core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_q[RST_STAGES-1];

  // convention: only a definite 1 selects the data-strobe form
  conv_e conv_q;
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)           conv_q <= CONV_SPLIT;
    else if (mode_pin == 1'b1) conv_q <= CONV_DS_RW;
    else                       conv_q <= CONV_SPLIT;
  end

  // pin sampling, a constant 1 rides along as the valid marker
  logic [SW-1:0]     sync_q;
  logic              valid_s, ce_n_s, as_s, ds_s, rw_s;
  logic [DATA_W-1:0] ad_s;

  mbi_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     ({1'b1, ce_n, as_pin, ds_pin, rw_pin, ad_in}),
    .q     (sync_q)
  );
  assign {valid_s, ce_n_s, as_s, ds_s, rw_s, ad_s} = sync_q;

  logic as_fall, wr_evt, rd_act, rd_start;

  mbi_strobe_decode u_dec (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .conv     (conv_q),
    .valid_s  (valid_s),
    .as_s     (as_s),
    .ds_s     (ds_s),
    .rw_s     (rw_s),
    .ce_n_s   (ce_n_s),
    .as_fall  (as_fall),
    .wr_evt   (wr_evt),
    .rd_act   (rd_act),
    .rd_start (rd_start)
  );

  // next state
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              wr_q, rd_q, oe_q;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (as_fall) addr_d  = ad_s[ADDR_W-1:0];
    if (wr_evt)  wdata_d = ad_s;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      wr_q    <= wr_evt;
      rd_q    <= rd_start;
      oe_q    <= rd_act;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_q;
  assign reg_rd    = rd_q;
  assign ad_oe     = oe_q;
  assign ad_out    = oe_q ? reg_rdata : '0;
endmodule

// File: rtl/mbi_front_checks.sv
module mbi_front_checks #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_n,
  input logic              valid_s,
  input logic              ce_n_s,
  input logic              as_fall,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              ad_oe,
  input logic [ADDR_W-1:0] reg_addr
);
  p_quiet_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (!reg_wr && !reg_rd && !ad_oe));

  p_addr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(reg_addr));

  p_wr_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(!ce_n_s && valid_s));

  p_drive_needs_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> $past(!ce_n_s && valid_s));

  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_rd_at_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> reg_rd);
endmodule

bind mbi_front mbi_front_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .valid_s    (valid_s),
  .ce_n_s     (ce_n_s),
  .as_fall    (as_fall),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .ad_oe      (ad_oe),
  .reg_addr   (reg_addr)
);

// File: tb/mbi_front_test.sv
module mbi_front_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 7;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n, mode_pin, as_pin, ds_pin, rw_pin, ce_n;
  logic [DW-1:0] ad_in, ad_out, reg_wdata, reg_rdata;
  logic          ad_oe, reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;

  int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
  logic [DW-1:0] last_wd;
  logic [AW-1:0] last_wa;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign reg_rdata = {1'b0, reg_addr} ^ 8'h5A;

  mbi_front uut (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .as_pin(as_pin),
    .ds_pin(ds_pin), .rw_pin(rw_pin), .ce_n(ce_n), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  always @(negedge clk) begin
    if (reg_wr) begin
      wr_cnt++;
      last_wd = reg_wdata;
      last_wa = reg_addr;
    end
    if (reg_rd) rd_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle(input logic m);
    ce_n = 1'b1; as_pin = 1'b0; rw_pin = 1'b1;
    ds_pin = m ? 1'b0 : 1'b1;
    step(4);
    mode_pin = m;
    step(4);
  endtask

  task automatic addr_phase(input logic [DW-1:0] a);
    ad_in = a; as_pin = 1'b1; step(3);
    as_pin = 1'b0; step(4);
  endtask

  task automatic t_reset;
    chk("R8 addr after reset", reg_addr, 0);
    chk("R8 oe after reset", ad_oe, 0);
    chk("R8 no write after reset", wr_cnt, 0);
  endtask

  task automatic t_latency;
    go_idle(1'b0);
    ad_in = 8'h15; as_pin = 1'b1; step(4);
    as_pin = 1'b0;
    step(2);
    chk("R9 addr not yet after 2 edges", reg_addr, 0);
    step(1);
    chk("R9 addr after 3 edges", reg_addr, 8'h15);
    step(3);
  endtask

  task automatic t_split_write;
    int w0 = wr_cnt;
    addr_phase(8'h23);
    chk("R2 addr captured", reg_addr, 8'h23);
    ce_n = 1'b0; ad_in = 8'hC4; rw_pin = 1'b0; step(4);
    chk("R5 no write before wr strobe rises", wr_cnt, w0);
    rw_pin = 1'b1; step(4);
    ce_n = 1'b1;
    chk("R5 one write", wr_cnt, w0 + 1);
    chk("R5 write data", last_wd, 8'hC4);
    chk("R5 write addr", last_wa, 8'h23);
  endtask

  task automatic t_split_read;
    int r0 = rd_cnt;
    ce_n = 1'b0; ds_pin = 1'b0; step(4);
    chk("R6 oe during read", ad_oe, 1);
    chk("R6 read data", ad_out, 8'h23 ^ 8'h5A);
    chk("R7 one read pulse", rd_cnt, r0 + 1);
    ds_pin = 1'b1; step(4);
    chk("R6 oe released", ad_oe, 0);
    chk("R6 bus value idle", ad_out, 0);
    ce_n = 1'b1; ds_pin = 1'b0; step(4);
    chk("R3 no drive with ce high", ad_oe, 0);
    chk("R3 no read with ce high", rd_cnt, r0 + 1);
    ds_pin = 1'b1; step(2);
  endtask

  task automatic t_ce_high_addr;
    int w0 = wr_cnt;
    addr_phase(8'h4E);
    chk("R2 addr latched with ce high", reg_addr, 8'h4E);
    ad_in = 8'h99; rw_pin = 1'b0; step(4); rw_pin = 1'b1; step(4);
    chk("R3 no write with ce high", wr_cnt, w0);
    chk("R2 addr held after data phase", reg_addr, 8'h4E);
  endtask

  task automatic t_ds_write_read;
    int w0 = wr_cnt, r0 = rd_cnt;
    go_idle(1'b1);
    addr_phase(8'h31);
    ce_n = 1'b0; rw_pin = 1'b0; ad_in = 8'h6B; step(2);
    ds_pin = 1'b1; step(4);
    chk("R4 no read while rw low", ad_oe, 0);
    ds_pin = 1'b0; step(4);
    rw_pin = 1'b1; step(2);
    chk("R4 one write", wr_cnt, w0 + 1);
    chk("R4 write data", last_wd, 8'h6B);
    chk("R1 rw strobe ignored in ds mode", wr_cnt, w0 + 1);
    ds_pin = 1'b1; step(4);
    chk("R6 ds read drives", ad_oe, 1);
    chk("R6 ds read data", ad_out, 8'h31 ^ 8'h5A);
    chk("R7 ds read pulse", rd_cnt, r0 + 1);
    ds_pin = 1'b0; step(4);
    chk("R4 ds fall with rw high no write", wr_cnt, w0 + 1);
    chk("R6 ds read ends", ad_oe, 0);
    ce_n = 1'b1;
  endtask

  task automatic t_undriven_mode;
    int w0 = wr_cnt;
    go_idle(1'b0);
    mode_pin = 1'bz; step(3);
    addr_phase(8'h12);
    ce_n = 1'b0; ad_in = 8'hE1; rw_pin = 1'b0; step(4);
    rw_pin = 1'b1; step(4); ce_n = 1'b1;
    chk("R1 undriven mode uses split strobes", wr_cnt, w0 + 1);
    chk("R1 undriven mode write data", last_wd, 8'hE1);
  endtask

  task automatic t_mid_reset;
    int w0 = wr_cnt;
    rst_n = 1'b0; step(1);
    ce_n = 1'b0; ad_in = 8'h07; as_pin = 1'b1; step(3); as_pin = 1'b0;
    rw_pin = 1'b0; step(3); rw_pin = 1'b1; ds_pin = 1'b0; step(4);
    chk("R8 no drive in reset", ad_oe, 0);
    chk("R8 addr cleared in reset", reg_addr, 0);
    chk("R8 no write in reset", wr_cnt, w0);
    ds_pin = 1'b1; ce_n = 1'b1; step(2);
    rst_n = 1'b1; step(6);
    chk("R8 quiet after release", wr_cnt, w0);
    chk("R8 addr zero after release", reg_addr, 0);
  endtask

  initial begin
    rst_n = 1'b0; mode_pin = 1'b0; as_pin = 1'b0; ds_pin = 1'b1;
    rw_pin = 1'b1; ce_n = 1'b1; ad_in = '0;
    step(4);
    rst_n = 1'b1;
    step(6);
    t_reset();
    t_latency();
    t_split_write();
    t_split_read();
    t_ce_high_addr();
    t_ds_write_read();
    t_undriven_mode();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule